// File: doc/BRIEF.md
# External Transfer Request Sampler

This block watches an asynchronous, active-low transfer request pin and turns it into a clean internal request for a transfer channel. The pin is registered on the rising edge of the bus clock through a two-stage synchronizer. A mode input selects how a request is recognised: either a high-to-low transition on the pin, or the pin simply being low. Each time a request is recognised, the block raises an acknowledge output for a single cycle.

After a request is acknowledged, the block holds back the internal transfer request until a fixed minimum latency has elapsed. It then keeps the request up until the bus side reports that the transfer bus cycle has started. When the pin is sampled again depends on the configuration. In single-address mode, sampling resumes one cycle after the transfer cycle begins. In dual-address mode, sampling resumes after a parameterised gap. When edge detection is combined with burst mode, the pin is never sampled again: the request stays asserted for the whole burst until the channel is disabled.

The controller is a five-state machine:
- IDLE: the pin is being sampled.
- HOLD: the minimum-latency wait.
- REQ: the request is raised and the block waits for the cycle start.
- XFER: the transfer cycle is running and sampling is suspended.
- BURST: an edge-triggered burst, with no further sampling.

The transitions are:
- IDLE→HOLD when a request is recognised.
- HOLD→REQ when the latency count expires.
- REQ→XFER when the cycle starts, in any configuration other than edge burst.
- REQ→BURST when the cycle starts in edge burst.
- XFER→IDLE when the resample gap ends.
- Any state→IDLE when the channel enable is low.

Top module: `xfer_req_sampler`

## Requirements
- R1: While reset is held and in the first sampled cycle after it, `ack` and `xfer_req` are low.
- R2: With `level_mode`=1 and the block idle, a low pin first captured at a rising edge gives `ack`=1 in the cycle that follows the next rising edge. That is 2 clock cycles after the pin is driven low.
- R3: With `level_mode`=0, only a high-to-low transition is recognised, and `ack` rises 3 cycles after the pin falls. A pin that stays low produces no further `ack`. A new fall made from the idle state is recognised again with the same 3-cycle latency.
- R4: `xfer_req` rises exactly MIN_LAT cycles (default 4) after the cycle in which `ack` is high. It then stays high until `cycle_start` is seen.
- R5: When a transfer ends and the pin is held low in level mode, the next `ack` comes 3 cycles after the `cycle_start` cycle when `single_addr`=1, and 4 cycles after it when `single_addr`=0 (DUAL_GAP=2).
- R6: `ack` is high for exactly one cycle for each recognised request.
- R7: With `level_mode`=0 and `burst`=1, `xfer_req` stays high after `cycle_start` and the pin is not sampled, so no `ack` appears even when the pin falls again. This lasts until `chan_en` goes low.
- R8: Pin edges that arrive while an acknowledged request is waiting for its transfer are discarded rather than queued.
- R9: When `chan_en` is low, the next cycle has `xfer_req`=0 and `ack`=0, and the block returns to IDLE.
- R10: `xfer_req` is low in the cycle after `cycle_start`, except in edge-burst configuration, where it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the pin is captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin_n | input | 1 | Asynchronous active-low request pin |
| level_mode | input | 1 | 1 = low-level detection, 0 = falling-edge detection |
| burst | input | 1 | 1 = burst transfer mode, 0 = cycle-steal |
| single_addr | input | 1 | 1 = single-address transfers, 0 = dual-address |
| cycle_start | input | 1 | Bus side reports that the transfer bus cycle has begun |
| chan_en | input | 1 | Channel enable; low returns the block to idle |
| xfer_req | output | 1 | Internal transfer request to the channel logic |
| ack | output | 1 | One-cycle acknowledge per recognised request |

## Verification
The bench sweeps all eight combinations of detect mode, burst and address mode, each with three different delays between the request rising and the cycle start. Counting cycles from the pin fall to `ack` separates the one-stage level path from the two-stage edge path. Counting from `ack` to `xfer_req` pins down the latency window.

After each cycle start, the pin is handled in one of three ways:
- In level mode it is held low, which exposes the single- versus dual-address resample point.
- In edge burst it is toggled, which must produce no acknowledge.
- In edge cycle-steal it is held steady, which must produce no acknowledge; then a fresh fall must be acknowledged.

A pulse on the pin during the latency wait shows that edges are not queued.

// File: rtl/xreq_pkg.sv
package xreq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_REQ   = 3'd2,
        ST_XFER  = 3'd3,
        ST_BURST = 3'd4
    } xreq_state_e;
endpackage

// File: rtl/xreq_sync.sv
// Shift-register synchronizer for the active-low request pin.
module xreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic early_n,
    output logic sync_n
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign early_n = q[0];
    assign sync_n  = q[STAGES-1];
endmodule

// File: rtl/xreq_detect.sv
// Selects level or falling-edge recognition of the synchronized pin.
module xreq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic early_n,
    input  logic sync_n,
    output logic hit
);
    logic prev_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= sync_n;
    end

    always_comb begin
        if (level_mode) hit = ~early_n;
        else            hit = prev_n & ~sync_n;
    end
endmodule

// File: rtl/xfer_req_sampler.sv
module xfer_req_sampler
    import xreq_pkg::*;
#(
    parameter int MIN_LAT     = 4,
    parameter int DUAL_GAP    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pin_n,
    input  logic level_mode,
    input  logic burst,
    input  logic single_addr,
    input  logic cycle_start,
    input  logic chan_en,
    output logic xfer_req,
    output logic ack
);
    localparam int LIM = (MIN_LAT > DUAL_GAP) ? MIN_LAT : DUAL_GAP;
    localparam int CW  = $clog2(LIM + 1);

    logic        early_n, sync_n, hit;
    logic [CW-1:0] cnt;
    logic [CW-1:0] gap_last;
    xreq_state_e state, state_nxt;

    xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (req_pin_n),
        .early_n (early_n),
        .sync_n  (sync_n)
    );

    xreq_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (level_mode),
        .early_n    (early_n),
        .sync_n     (sync_n),
        .hit        (hit)
    );

    assign gap_last = single_addr ? CW'(0) : CW'(DUAL_GAP - 1);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (!chan_en) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (hit) state_nxt = ST_HOLD;
                ST_HOLD:  if (cnt == CW'(MIN_LAT - 1)) state_nxt = ST_REQ;
                ST_REQ:   if (cycle_start)
                              state_nxt = (burst && !level_mode) ? ST_BURST : ST_XFER;
                ST_XFER:  if (cnt == gap_last) state_nxt = ST_IDLE;
                ST_BURST: state_nxt = ST_BURST;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register and dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state)
                cnt <= '0;
            else if (state == ST_HOLD || state == ST_XFER)
                cnt <= cnt + CW'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= chan_en && (state == ST_IDLE) && hit;
    end

    always_comb begin
        xfer_req = (state == ST_REQ) || (state == ST_BURST);
    end
endmodule

// File: rtl/xfer_req_sampler_chk.sv
module xfer_req_sampler_chk #(
    parameter int MIN_LAT = 4
) (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic xfer_req,
    input logic ack
);
    int since_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_ack <= 0;
        else if (ack)               since_ack <= 1;
        else if (since_ack < MIN_LAT) since_ack <= since_ack + 1;
    end

    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_min_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> (since_ack >= MIN_LAT));

    assert_ack_excl_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !xfer_req);

    assert_no_ack_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(xfer_req));

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!xfer_req && !ack));
endmodule

bind xfer_req_sampler xfer_req_sampler_chk #(.MIN_LAT(MIN_LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .xfer_req (xfer_req),
    .ack      (ack)
);

// File: tb/xfer_req_sampler_bench.sv
module xfer_req_sampler_bench;
    logic clk = 1'b0;
    logic rst_n, req_pin_n, level_mode, burst, single_addr, cycle_start, chan_en;
    logic xfer_req, ack;
    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 1'b0;

    always #10 clk = ~clk;

    xfer_req_sampler u_xfer_req_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_pin_n   (req_pin_n),
        .level_mode  (level_mode),
        .burst       (burst),
        .single_addr (single_addr),
        .cycle_start (cycle_start),
        .chan_en     (chan_en),
        .xfer_req    (xfer_req),
        .ack         (ack)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (lvl=%0d burst=%0d sa=%0d)",
                     req, act, exp, level_mode, burst, single_addr);
        end
    endtask

    task automatic run_case(input int lv, input int bu, input int sa, input int d);
        int  n, m, acks, first;
        bit  eb, xr_ok;
        eb = (lv == 0) && (bu == 1);
        level_mode  = 1'(lv);
        burst       = 1'(bu);
        single_addr = 1'(sa);
        chan_en     = 1'b1;
        req_pin_n   = 1'b1;
        repeat (4) tick();

        // R2 / R3: detection latency
        req_pin_n = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!ack && n < 20);
        if (lv != 0) chk(n == 2, "R2", n, 2);
        else         chk(n == 3, "R3", n, 3);

        // pulse during the wait (R8), one cycle high
        if (lv == 0) req_pin_n = 1'b1;
        tick();
        chk(ack == 1'b0, "R6", int'(ack), 0);
        m = 1;
        if (lv == 0) req_pin_n = 1'b0;
        while (!xfer_req && m < 20) begin tick(); m++; end
        chk(m == 4, "R4", m, 4);

        for (int k = 0; k < d; k++) begin
            tick();
            chk(xfer_req == 1'b1, "R4", int'(xfer_req), 1);
        end

        cycle_start = 1'b1;
        tick();
        cycle_start = 1'b0;
        acks = 0; first = 0; xr_ok = 1'b1;
        for (int off = 1; off <= 12; off++) begin
            if (off == 1) chk(xfer_req == eb, "R10", int'(xfer_req), int'(eb));
            if (ack) begin
                acks++;
                if (first == 0) first = off;
            end
            if (eb && !xfer_req) xr_ok = 1'b0;
            if (!eb && lv == 0 && xfer_req) xr_ok = 1'b0;
            if (eb && off == 2) req_pin_n = 1'b1;
            if (eb && off == 4) req_pin_n = 1'b0;
            if (off < 12) tick();
        end

        if (eb) begin
            chk(acks == 0, "R7", acks, 0);
            chk(xr_ok, "R7", int'(xr_ok), 1);
        end else if (lv == 0) begin
            chk(acks == 0, "R8", acks, 0);
            chk(xr_ok, "R8", int'(xr_ok), 1);
            req_pin_n = 1'b1;
            repeat (3) tick();
            req_pin_n = 1'b0;
            n = 0;
            do begin tick(); n++; end while (!ack && n < 20);
            chk(n == 3, "R3", n, 3);
        end else begin
            chk(acks == 1, "R6", acks, 1);
            chk(first == (sa != 0 ? 3 : 4), "R5", first, (sa != 0 ? 3 : 4));
        end

        chan_en   = 1'b0;
        req_pin_n = 1'b1;
        tick();
        chk(!xfer_req && !ack, "R9", int'({xfer_req, ack}), 0);
        repeat (3) tick();
    endtask

    initial begin
        rst_n = 1'b0; req_pin_n = 1'b1; level_mode = 1'b0; burst = 1'b0;
        single_addr = 1'b0; cycle_start = 1'b0; chan_en = 1'b0;
        repeat (3) tick();
        chk(!ack && !xfer_req, "R1", int'({xfer_req, ack}), 0);
        rst_n = 1'b1;
        tick();
        chk(!ack && !xfer_req, "R1", int'({xfer_req, ack}), 0);
        for (int lv = 0; lv < 2; lv++)
            for (int bu = 0; bu < 2; bu++)
                for (int sa = 0; sa < 2; sa++)
                    for (int d = 0; d < 3; d++)
                        run_case(lv, bu, sa, d);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule